// File: doc/BRIEF.md
# Two-Wire Serial Target Engine

This block is a 7-bit-address target for a two-wire serial bus of the I2C kind. Both bus lines reach it as plain inputs and are oversampled on the system clock. The block pulls the data line low only through an open-drain enable. It finds bus START and STOP events and collects the address byte. It then either takes in data bytes from the controller or sends data bytes to it, and handles the acknowledge slot in the ninth clock correctly for each direction.

On the local side, a host reads a received-byte register guarded by a full flag and a sticky overflow flag, and loads outgoing bytes through a load strobe.

The controller is a single finite-state machine with these states:
- `ST_IDLE`: the bus is free.
- `ST_ADDR`: the address byte is being shifted in.
- `ST_ADDR_ACK`: the address acknowledge slot.
- `ST_RX`: a data byte is being received.
- `ST_RX_ACK`: the acknowledge slot after a received byte.
- `ST_TX`: a data byte is being sent.
- `ST_TX_ACK`: the slot where the controller acknowledges a sent byte.
- `ST_HUSH`: the engine is silent until the next bus event.

The transitions are:
- START from any state goes to `ST_ADDR`.
- STOP from any state goes to `ST_IDLE`.
- From `ST_ADDR`: a match goes to `ST_ADDR_ACK`; a mismatch goes to `ST_HUSH`.
- From `ST_ADDR_ACK`: the engine goes to `ST_RX` for a write or `ST_TX` for a read.
- `ST_RX` goes to `ST_RX_ACK`. From there, an accepted byte returns to `ST_RX` and a refused byte goes to `ST_HUSH`.
- `ST_TX` goes to `ST_TX_ACK`. From there, a controller ACK returns to `ST_TX` and a controller NACK goes to `ST_HUSH`.

Top module: `i2c_target_engine`

## Requirements
- R1: After reset, `sda_oe`, `rx_full` and `rx_overflow` are all 0.
- R2: START is detected when the data line falls while the clock line is high. It starts a fresh address phase from any state and drops a partly received byte. STOP is detected when the data line rises while the clock line is high. It returns the engine to idle with the data line released.
- R3: The first byte after START is taken MSB first. Its bits 7:1 are compared with `match_addr[7:1]`, so address 0x2A matches a first byte of 0x54 or 0x55. Bit 0 of that byte set to 1 selects a read. On a match, the engine holds the data line low through the ninth clock.
- R4: A first byte that does not match is not acknowledged. Until the next START or STOP, the engine never pulls the data line low and stores nothing.
- R5: In a write, each data byte is shifted in MSB first and placed in `rx_data`. `rx_full` rises on the third system clock edge after the eighth clock-line rise at the pin. The byte is acknowledged in the ninth clock.
- R6: A one-cycle `rx_rd` clears `rx_full` and `rx_overflow` and leaves `rx_data` unchanged.
- R7: If `rx_full` is still 1 when a byte completes, the following happens:
  - `rx_overflow` is set.
  - The new byte is dropped.
  - The byte is not acknowledged.
  - Later bytes are ignored until START or STOP.
- R8: If `rx_rd` falls in the same cycle as a byte completing, the read and the new byte both take effect. The new byte is stored and acknowledged, `rx_full` stays 1, and `rx_overflow` stays 0.
- R9: In a read, the byte last captured by `tx_load` is sent MSB first. The first bit is driven after the address acknowledge. After each controller ACK, the register is sampled again for the next byte.
- R10: After a controller NACK on a sent byte, the engine releases the data line and never pulls it low again before START or STOP.
- R11: The engine changes `sda_oe` only while the clock line is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| sda_oe | output | 1 | 1 pulls the data line low |
| match_addr | input | 7 | Own address placed in bit positions 7:1 |
| tx_data | input | 8 | Byte to be sent in read transfers |
| tx_load | input | 1 | Captures `tx_data` into the send register |
| rx_data | output | 8 | Last accepted received byte |
| rx_full | output | 1 | A received byte waits for the host |
| rx_overflow | output | 1 | A byte arrived while the buffer was full |
| rx_rd | input | 1 | Host read strobe: clears both flags |

## Verification
The host read strobe and the completion of a received byte can land in the same system cycle. The outcome decides between storing and acknowledging the new byte, or dropping and refusing it. The bench counts the synchronizer latency from the eighth clock-line rise and pulses `rx_rd` for exactly the cycle in which the byte is stored. It then judges the result by four things: the acknowledge seen on the wired data line, the new value in `rx_data`, `rx_full` still set, and `rx_overflow` still clear.

// File: rtl/i2c_target_pkg.sv
package i2c_target_pkg;
    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_RX,
        ST_RX_ACK,
        ST_TX,
        ST_TX_ACK,
        ST_HUSH
    } tgt_state_t;
endpackage

// File: rtl/i2c_line_cond.sv
module i2c_line_cond #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [STAGES-1:0] scl_pipe;
    logic [STAGES-1:0] sda_pipe;
    logic              scl_q;
    logic              sda_q;

    // Idle bus is high, so reset to 1 to avoid false events.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_q    <= 1'b1;
            sda_q    <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
            sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
            scl_q    <= scl_s;
            sda_q    <= sda_s;
        end
    end

    assign scl_s     = scl_pipe[STAGES-1];
    assign sda_s     = sda_pipe[STAGES-1];
    assign scl_rise  = scl_s & ~scl_q;
    assign scl_fall  = ~scl_s & scl_q;
    assign start_det = scl_s & scl_q & sda_q & ~sda_s;
    assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/i2c_rx_hold.sv
module i2c_rx_hold #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         rd,
    output logic [W-1:0] data,
    output logic         full,
    output logic         ovf,
    output logic         accept
);
    // A read in the same cycle frees the slot for the arriving byte.
    assign accept = ~full | rd;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data <= '0;
            full <= 1'b0;
            ovf  <= 1'b0;
        end else begin
            if (push && accept) begin
                data <= push_data;
                full <= 1'b1;
            end else if (rd) begin
                full <= 1'b0;
            end
            if (rd)
                ovf <= 1'b0;
            else if (push && !accept)
                ovf <= 1'b1;
        end
    end
endmodule

// File: rtl/i2c_target_engine.sv
module i2c_target_engine
    import i2c_target_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    input  logic [BYTE_W-1:1] match_addr,
    input  logic [BYTE_W-1:0] tx_data,
    input  logic              tx_load,
    output logic [BYTE_W-1:0] rx_data,
    output logic              rx_full,
    output logic              rx_overflow,
    input  logic              rx_rd
);
    localparam int              CNT_W    = $clog2(BYTE_W);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

    logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;

    tgt_state_t        state;
    logic [CNT_W-1:0]  bit_cnt;
    logic [BYTE_W-2:0] in_sh;
    logic [BYTE_W-1:0] out_sh;
    logic [BYTE_W-1:0] tx_reg;
    logic              ph9;
    logic              ack_ok;
    logic              rw_rd;
    logic              m_ack;
    logic              push;
    logic              accept;
    logic [BYTE_W-1:0] byte_in;

    i2c_line_cond #(.STAGES(SYNC_STAGES)) u_lines (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    assign byte_in = {in_sh, sda_s};
    assign push    = (state == ST_RX) && scl_rise && (bit_cnt == LAST_BIT);

    i2c_rx_hold #(.W(BYTE_W)) u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .push_data (byte_in),
        .rd        (rx_rd),
        .data      (rx_data),
        .full      (rx_full),
        .ovf       (rx_overflow),
        .accept    (accept)
    );

    // State register and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            bit_cnt <= '0;
            in_sh   <= '0;
            out_sh  <= '1;
            tx_reg  <= '0;
            ph9     <= 1'b0;
            ack_ok  <= 1'b0;
            rw_rd   <= 1'b0;
            m_ack   <= 1'b0;
        end else begin
            if (tx_load)
                tx_reg <= tx_data;
            if (start_det) begin
                state   <= ST_ADDR;
                bit_cnt <= '0;
                ph9     <= 1'b0;
            end else if (stop_det) begin
                state <= ST_IDLE;
                ph9   <= 1'b0;
            end else begin
                unique case (state)
                    ST_IDLE, ST_HUSH: ;
                    ST_ADDR: if (scl_rise) begin
                        in_sh <= byte_in[BYTE_W-2:0];
                        if (bit_cnt == LAST_BIT) begin
                            bit_cnt <= '0;
                            if (byte_in[BYTE_W-1:1] == match_addr) begin
                                state <= ST_ADDR_ACK;
                                rw_rd <= byte_in[0];
                                ph9   <= 1'b0;
                            end else begin
                                state <= ST_HUSH;
                            end
                        end else begin
                            bit_cnt <= bit_cnt + 1'b1;
                        end
                    end
                    ST_ADDR_ACK: if (scl_fall) begin
                        if (!ph9) begin
                            ph9 <= 1'b1;
                        end else begin
                            ph9     <= 1'b0;
                            bit_cnt <= '0;
                            if (rw_rd) begin
                                state  <= ST_TX;
                                out_sh <= tx_reg;
                            end else begin
                                state <= ST_RX;
                            end
                        end
                    end
                    ST_RX: if (scl_rise) begin
                        in_sh <= byte_in[BYTE_W-2:0];
                        if (bit_cnt == LAST_BIT) begin
                            bit_cnt <= '0;
                            state   <= ST_RX_ACK;
                            ack_ok  <= accept;
                            ph9     <= 1'b0;
                        end else begin
                            bit_cnt <= bit_cnt + 1'b1;
                        end
                    end
                    ST_RX_ACK: if (scl_fall) begin
                        if (!ph9) begin
                            ph9 <= 1'b1;
                        end else begin
                            ph9   <= 1'b0;
                            state <= ack_ok ? ST_RX : ST_HUSH;
                        end
                    end
                    ST_TX: if (scl_fall) begin
                        out_sh <= {out_sh[BYTE_W-2:0], 1'b1};
                    end else if (scl_rise) begin
                        if (bit_cnt == LAST_BIT) begin
                            bit_cnt <= '0;
                            state   <= ST_TX_ACK;
                            ph9     <= 1'b0;
                        end else begin
                            bit_cnt <= bit_cnt + 1'b1;
                        end
                    end
                    ST_TX_ACK: if (scl_rise && ph9) begin
                        m_ack <= ~sda_s;
                    end else if (scl_fall) begin
                        if (!ph9) begin
                            ph9 <= 1'b1;
                        end else begin
                            ph9 <= 1'b0;
                            if (m_ack) begin
                                state   <= ST_TX;
                                out_sh  <= tx_reg;
                                bit_cnt <= '0;
                            end else begin
                                state <= ST_HUSH;
                            end
                        end
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end

    // Output decode
    always_comb begin
        sda_oe = 1'b0;
        unique case (state)
            ST_ADDR_ACK: sda_oe = ph9;
            ST_RX_ACK:   sda_oe = ph9 & ack_ok;
            ST_TX:       sda_oe = ~out_sh[BYTE_W-1];
            ST_TX_ACK:   sda_oe = ~ph9 & ~out_sh[BYTE_W-1];
            default:     sda_oe = 1'b0;
        endcase
    end
endmodule

// File: rtl/i2c_target_engine_chk.sv
module i2c_target_engine_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       scl_s,
    input logic       start_det,
    input logic       stop_det,
    input logic       sda_oe,
    input logic       rx_rd,
    input logic       rx_full,
    input logic       rx_overflow,
    input logic [7:0] rx_data
);
    // R11
    sda_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_s && !start_det && !stop_det) |=> $stable(sda_oe));

    // R2
    stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !sda_oe);

    // R2
    start_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> !sda_oe);

    // R6
    rd_clears_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_rd |=> !rx_overflow);

    // R6
    full_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_full && !rx_rd) |=> rx_full);

    // R7
    ovf_keeps_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_overflow) |-> (rx_full && $stable(rx_data)));
endmodule

bind i2c_target_engine i2c_target_engine_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .scl_s       (scl_s),
    .start_det   (start_det),
    .stop_det    (stop_det),
    .sda_oe      (sda_oe),
    .rx_rd       (rx_rd),
    .rx_full     (rx_full),
    .rx_overflow (rx_overflow),
    .rx_data     (rx_data)
);

// File: tb/i2c_target_engine_tb.sv
module i2c_target_engine_tb;
    localparam int Q = 6;
    localparam logic [7:1] OWN = 7'h2A;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic       sda_oe;
    logic [7:1] match_addr = OWN;
    logic [7:0] tx_data = 8'h00;
    logic       tx_load = 1'b0;
    logic [7:0] rx_data;
    logic       rx_full;
    logic       rx_overflow;
    logic       rx_rd = 1'b0;
    logic       sda_line;

    int total = 0;
    int bad = 0;
    int hold_viol = 0;
    logic prev_scl = 1'b1;
    logic prev_oe = 1'b0;

    assign sda_line = sda_m & ~sda_oe;

    always #2.5 clk = ~clk;

    i2c_target_engine u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .scl_i       (scl_m),
        .sda_i       (sda_line),
        .sda_oe      (sda_oe),
        .match_addr  (match_addr),
        .tx_data     (tx_data),
        .tx_load     (tx_load),
        .rx_data     (rx_data),
        .rx_full     (rx_full),
        .rx_overflow (rx_overflow),
        .rx_rd       (rx_rd)
    );

    // R11 monitor: sda_oe must not move while SCL stays high at the pin
    always @(negedge clk) begin
        if (rst_n && prev_scl && scl_m && (sda_oe != prev_oe))
            hold_viol++;
        prev_scl <= scl_m;
        prev_oe  <= sda_oe;
    end

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wait_clk(Q);
        scl_m = 1'b1; wait_clk(Q);
        sda_m = 1'b0; wait_clk(Q);
        scl_m = 1'b0; wait_clk(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wait_clk(Q);
        scl_m = 1'b1; wait_clk(Q);
        sda_m = 1'b1; wait_clk(Q);
    endtask

    task automatic clock_bit(input logic b, output logic s);
        sda_m = b;    wait_clk(Q);
        scl_m = 1'b1; wait_clk(Q);
        s = sda_line; wait_clk(Q);
        scl_m = 1'b0; wait_clk(Q);
    endtask

    // mode 0: plain, 1: check full latency, 2: host read in the store cycle
    task automatic write_byte(input logic [7:0] b, input int mode, output logic ack);
        logic s;
        for (int i = 7; i >= 1; i--) clock_bit(b[i], s);
        sda_m = b[0]; wait_clk(Q);
        scl_m = 1'b1;
        @(posedge clk); @(posedge clk); @(negedge clk);
        if (mode == 1) check("R5 full before 3rd edge", rx_full, 0);
        if (mode == 2) rx_rd = 1'b1;
        @(negedge clk);
        rx_rd = 1'b0;
        if (mode == 1) check("R5 full at 3rd edge", rx_full, 1);
        wait_clk(2 * Q - 2);
        scl_m = 1'b0; wait_clk(Q);
        clock_bit(1'b1, s);
        ack = ~s;
    endtask

    task automatic read_bits(output logic [7:0] d);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            clock_bit(1'b1, s);
            d[i] = s;
        end
    endtask

    task automatic load_tx(input logic [7:0] v);
        @(negedge clk);
        tx_data = v; tx_load = 1'b1;
        @(negedge clk);
        tx_load = 1'b0;
    endtask

    task automatic host_read();
        @(negedge clk); rx_rd = 1'b1;
        @(negedge clk); rx_rd = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 sda_oe", sda_oe, 0);
        check("R1 rx_full", rx_full, 0);
        check("R1 rx_overflow", rx_overflow, 0);
    endtask

    task automatic t_write();
        logic ack;
        bus_start();
        write_byte(8'h54, 0, ack);
        check("R3 write address acked", ack, 1);
        write_byte(8'hA5, 1, ack);
        check("R5 data acked", ack, 1);
        check("R5 rx_data", rx_data, 8'hA5);
        host_read();
        check("R6 full cleared", rx_full, 0);
        check("R6 data kept", rx_data, 8'hA5);
        write_byte(8'h3C, 0, ack);
        check("R5 second byte acked", ack, 1);
        check("R5 second rx_data", rx_data, 8'h3C);
        bus_stop();
        check("R2 released after stop", sda_oe, 0);
        host_read();
    endtask

    task automatic t_mismatch();
        logic ack;
        bus_start();
        write_byte(8'h40, 0, ack);
        check("R4 address not acked", ack, 0);
        write_byte(8'h00, 0, ack);
        check("R4 data ignored no ack", ack, 0);
        check("R4 nothing stored", rx_full, 0);
        bus_stop();
    endtask

    task automatic t_overflow();
        logic ack;
        bus_start();
        write_byte(8'h54, 0, ack);
        write_byte(8'h5A, 0, ack);
        check("R7 first byte acked", ack, 1);
        write_byte(8'h6B, 0, ack);
        check("R7 overflow byte nacked", ack, 0);
        check("R7 overflow set", rx_overflow, 1);
        check("R7 byte dropped", rx_data, 8'h5A);
        write_byte(8'h77, 0, ack);
        check("R7 later byte ignored", ack, 0);
        check("R7 data still old", rx_data, 8'h5A);
        bus_stop();
        host_read();
        check("R6 overflow cleared", rx_overflow, 0);
        check("R6 full cleared after overflow", rx_full, 0);
    endtask

    task automatic t_same_cycle();
        logic ack;
        bus_start();
        write_byte(8'h54, 0, ack);
        write_byte(8'h11, 0, ack);
        write_byte(8'h22, 2, ack);
        check("R8 byte acked on same-cycle read", ack, 1);
        check("R8 new data stored", rx_data, 8'h22);
        check("R8 full held", rx_full, 1);
        check("R8 no overflow", rx_overflow, 0);
        bus_stop();
        host_read();
    endtask

    task automatic t_read();
        logic ack;
        logic s;
        logic [7:0] d;
        load_tx(8'hC3);
        bus_start();
        write_byte(8'h55, 0, ack);
        check("R3 read address acked", ack, 1);
        read_bits(d);
        check("R9 first byte", d, 8'hC3);
        load_tx(8'h5E);
        clock_bit(1'b0, s);
        read_bits(d);
        check("R9 reloaded byte", d, 8'h5E);
        clock_bit(1'b1, s);
        read_bits(d);
        check("R10 line released after nack", d, 8'hFF);
        check("R10 sda_oe idle", sda_oe, 0);
        bus_stop();
    endtask

    task automatic t_restart();
        logic ack;
        logic s;
        logic [7:0] d;
        bus_start();
        write_byte(8'h54, 0, ack);
        clock_bit(1'b0, s);
        clock_bit(1'b0, s);
        clock_bit(1'b0, s);
        bus_start();
        write_byte(8'h55, 0, ack);
        check("R2 repeated start address acked", ack, 1);
        check("R2 partial byte dropped", rx_full, 0);
        read_bits(d);
        check("R9 byte after restart", d, 8'h5E);
        clock_bit(1'b1, s);
        bus_stop();
        check("R2 idle after stop", sda_oe, 0);
    endtask

    initial begin
        #3_000_000;
        bad++;
        total++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        wait_clk(4);
        t_reset();
        rst_n = 1'b1;
        wait_clk(4);
        t_reset();
        t_write();
        t_mismatch();
        t_overflow();
        t_same_cycle();
        t_read();
        t_restart();
        check("R11 sda_oe moves only while SCL low", hold_viol, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule